// File: doc/BRIEF.md
# Fractional Clock Divider with Source Select

This block produces the common timing tick for a group of pulse-transmit channels. It picks one of three source clock enables, counts that source's pulses and emits a one-cycle tick. The divide ratio is an integer part plus one plus a fraction. The sources are enable pulses in the block's own clock domain, so the block never crosses clock domains and never gates a clock.

Software-facing logic drives a new configuration onto the field inputs and then pulses an apply strobe. The configuration holds the source code, the integer part, the fractional numerator and the fractional denominator. The block checks the fields on that strobe. A valid set replaces the running settings and restarts the divider. An invalid set is refused: it raises an error flag and leaves the running settings as they were.

The fraction works by dithering. At each tick the numerator is added to an accumulator. During the next period, each source pulse after the integer count has been met takes the denominator out of the accumulator if the accumulator holds at least the denominator. That pulse is spent as an extra source cycle.

Top module: `frac_tick_div`

## Requirements
- R1: After reset, `tick_o` and `cfg_err_o` are 0. The running settings are source code 1, integer part 0 and fraction disabled, so every pulse on `src_en_i[0]` produces a tick.
- R2: Source code c (1 = bus clock, 2 = 20 MHz internal oscillator, 3 = crystal) selects `src_en_i[c-1]`. Pulses on the other source bits have no effect on the tick timing.
- R3: When the numerator or the denominator is 0, the fraction is disabled. The k-th tick after an accepted apply then follows exactly k*(I+1) selected pulses, where I is the 8-bit integer part, I = 255 included.
- R4: With a numerator N and a denominator D, both non-zero, the k-th tick after an accepted apply follows exactly k*(I+1) + floor((k-1)*N/D) selected pulses. The long-run ratio is therefore I+1+N/D. This also holds for N greater than D.
- R5: An apply with a numerator above 64, a denominator above 64, or a source code of 0 is refused. `cfg_err_o` is 1 from the next cycle, and the previously applied settings and the divider state stay in effect.
- R6: An accepted apply clears `cfg_err_o` on the next cycle. `cfg_err_o` and the running settings change only on an apply, so changing the field inputs without an apply has no effect.
- R7: `tick_o` rises in the cycle after the selected pulse that ends a period. It is a single-cycle pulse whenever the integer part is non-zero, and it is 0 in the cycle after an accepted apply.
- R8: A numerator and a denominator of exactly 64 are accepted. That is the boundary case, and it gives a ratio of I+2 after the first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_i | input | 3 | Source enable pulses; bit c-1 belongs to source code c |
| cfg_sel_i | input | 2 | Requested source code |
| cfg_int_i | input | 8 | Requested integer part |
| cfg_num_i | input | 7 | Requested fractional numerator |
| cfg_den_i | input | 7 | Requested fractional denominator |
| cfg_apply_i | input | 1 | Strobe that validates and applies the fields |
| tick_o | output | 1 | Divided tick enable |
| cfg_err_o | output | 1 | Last apply was refused |

## Verification
The assertions check the following on every cycle:
- every tick is preceded by a pulse of the selected source;
- a refused apply sets the error flag and freezes the settings;
- an accepted apply clears the flag and silences the next tick;
- the flag and the settings never move without a strobe;
- ticks are single-cycle for non-zero integer parts.

The exact tick positions cannot be expressed as a per-cycle property:
- the integer-only spacing;
- the dithered k*(I+1)+floor((k-1)*N/D) sequence, including N greater than D and the 64/64 boundary;
- the rejection of noisy pulses on unselected sources;
- the continuation of the old ratio after a refused apply.

Only the bench scenarios show these, by counting selected pulses up to each tick.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    // Geometry of the configuration fields
    parameter int NUM_SRC    = 3;
    parameter int INT_W      = 8;
    parameter int FRAC_W     = 7;
    parameter int FRAC_LIMIT = 64;

    localparam int SEL_W = $clog2(NUM_SRC + 1);
    localparam int ACC_W = FRAC_W + 1;

    // Source codes; code c selects source enable bit c-1
    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_OSC  = 2'd2,
        SRC_XTAL = 2'd3
    } src_code_e;

    typedef struct packed {
        src_code_e               sel;
        logic [INT_W-1:0]        int_part;
        logic [FRAC_W-1:0]       num;
        logic [FRAC_W-1:0]       den;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{
        sel:      SRC_BUS,
        int_part: '0,
        num:      '0,
        den:      '0
    };

    function automatic logic cfg_is_valid(input div_cfg_t c);
        logic sel_ok;
        sel_ok = (c.sel != SRC_NONE) && (int'(c.sel) <= NUM_SRC);
        return sel_ok && (int'(c.num) <= FRAC_LIMIT) && (int'(c.den) <= FRAC_LIMIT);
    endfunction

    function automatic logic frac_active(input div_cfg_t c);
        return (c.num != '0) && (c.den != '0);
    endfunction

endpackage

// File: rtl/fdiv_cfg_reg.sv
module fdiv_cfg_reg
    import frac_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     apply_i,
    input  div_cfg_t req_i,
    output div_cfg_t cur_o,
    output logic     restart_o,
    output logic     err_o
);

    logic     req_ok;
    div_cfg_t cur_q;
    logic     err_q;

    always_comb begin
        req_ok    = cfg_is_valid(req_i);
        restart_o = apply_i && req_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= CFG_RESET;
            err_q <= 1'b0;
        end else if (apply_i) begin
            err_q <= !req_ok;
            if (req_ok) begin
                cur_q <= req_i;
            end
        end
    end

    assign cur_o = cur_q;
    assign err_o = err_q;

endmodule

// File: rtl/fdiv_src_mux.sv
module fdiv_src_mux
    import frac_div_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_en_i,
    input  src_code_e          sel_i,
    output logic               pulse_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_en_i[g] && (int'(sel_i) == g + 1);
    end

    assign pulse_o = |hit;

endmodule

// File: rtl/fdiv_core.sv
module fdiv_core
    import frac_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart_i,
    input  logic     pulse_i,
    input  div_cfg_t cfg_i,
    output logic     tick_o
);

    logic [INT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic             tick_q;
    logic             frac_on;
    logic             base_done;
    logic             owe_extra;
    logic [ACC_W-1:0] den_w;
    logic [ACC_W-1:0] num_w;

    always_comb begin
        frac_on   = frac_active(cfg_i);
        den_w     = ACC_W'(cfg_i.den);
        num_w     = ACC_W'(cfg_i.num);
        base_done = (cnt_q == cfg_i.int_part);
        owe_extra = frac_on && (acc_q >= den_w);
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (pulse_i) begin
                if (!base_done) begin
                    cnt_q <= cnt_q + 1'b1;
                end else if (owe_extra) begin
                    acc_q <= acc_q - den_w;
                end else begin
                    tick_q <= 1'b1;
                    cnt_q  <= '0;
                    if (frac_on) begin
                        acc_q <= acc_q + num_w;
                    end
                end
            end
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
    import frac_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [SEL_W-1:0]   cfg_sel_i,
    input  logic [INT_W-1:0]   cfg_int_i,
    input  logic [FRAC_W-1:0]  cfg_num_i,
    input  logic [FRAC_W-1:0]  cfg_den_i,
    input  logic               cfg_apply_i,
    output logic               tick_o,
    output logic               cfg_err_o
);

    div_cfg_t req_cfg;
    div_cfg_t cur_cfg;
    logic     restart;
    logic     src_pulse;

    always_comb begin
        req_cfg.sel      = src_code_e'(cfg_sel_i);
        req_cfg.int_part = cfg_int_i;
        req_cfg.num      = cfg_num_i;
        req_cfg.den      = cfg_den_i;
    end

    fdiv_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .apply_i   (cfg_apply_i),
        .req_i     (req_cfg),
        .cur_o     (cur_cfg),
        .restart_o (restart),
        .err_o     (cfg_err_o)
    );

    fdiv_src_mux u_mux (
        .src_en_i (src_en_i),
        .sel_i    (cur_cfg.sel),
        .pulse_o  (src_pulse)
    );

    fdiv_core u_core (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .pulse_i   (src_pulse),
        .cfg_i     (cur_cfg),
        .tick_o    (tick_o)
    );

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
    import frac_div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  cfg_sel_i,
    input logic [FRAC_W-1:0] cfg_num_i,
    input logic [FRAC_W-1:0] cfg_den_i,
    input logic              cfg_apply_i,
    input logic              tick_o,
    input logic              cfg_err_o,
    input logic              src_pulse,
    input div_cfg_t          cur_cfg
);

    logic req_bad;
    assign req_bad = (int'(cfg_num_i) > FRAC_LIMIT) || (int'(cfg_den_i) > FRAC_LIMIT)
                     || (cfg_sel_i == '0);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!tick_o && !cfg_err_o));

    p_tick_from_src_r2: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(src_pulse));

    p_err_on_bad_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_apply_i && req_bad) |=> cfg_err_o);

    p_keep_cfg_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_apply_i && req_bad) |=> $stable(cur_cfg));

    p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_apply_i && !req_bad) |=> !cfg_err_o);

    p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_apply_i |=> $stable(cfg_err_o));

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_apply_i |=> $stable(cur_cfg));

    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_apply_i && !req_bad) |=> !tick_o);

    p_single_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (tick_o && (cur_cfg.int_part != '0) && !cfg_apply_i) |=> !tick_o);

endmodule

bind frac_tick_div fdiv_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_num_i   (cfg_num_i),
    .cfg_den_i   (cfg_den_i),
    .cfg_apply_i (cfg_apply_i),
    .tick_o      (tick_o),
    .cfg_err_o   (cfg_err_o),
    .src_pulse   (src_pulse),
    .cur_cfg     (cur_cfg)
);

// File: tb/frac_tick_div_bench.sv
`timescale 1ns/1ps
module frac_tick_div_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] src_en_i;
    logic [1:0] cfg_sel_i;
    logic [7:0] cfg_int_i;
    logic [6:0] cfg_num_i;
    logic [6:0] cfg_den_i;
    logic       cfg_apply_i;
    logic       tick_o;
    logic       cfg_err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    frac_tick_div u_frac_tick_div (
        .clk         (clk),
        .rst         (rst),
        .src_en_i    (src_en_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_int_i   (cfg_int_i),
        .cfg_num_i   (cfg_num_i),
        .cfg_den_i   (cfg_den_i),
        .cfg_apply_i (cfg_apply_i),
        .tick_o      (tick_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive fields and pulse apply; afterwards scramble the fields (R6: no effect without apply)
    task automatic do_apply(input int sel, input int ip, input int nu, input int de);
        @(negedge clk);
        src_en_i    = '0;
        cfg_sel_i   = 2'(sel);
        cfg_int_i   = 8'(ip);
        cfg_num_i   = 7'(nu);
        cfg_den_i   = 7'(de);
        cfg_apply_i = 1'b1;
        @(negedge clk);
        cfg_apply_i = 1'b0;
        cfg_int_i   = ~8'(ip);
        cfg_num_i   = 7'd99;
        cfg_den_i   = 7'd3;
        cfg_sel_i   = 2'd0;
    endtask

    // Run the selected source with period 'gap', others always busy, and check each tick position
    task automatic measure(input string req, input int sel, input int ip, input int nu,
                           input int de, input int kt, input int gap);
        int  pulses = 0;
        int  ticks  = 0;
        int  cyc    = 0;
        bit  prev_t = 0;
        bit  frac   = (nu != 0) && (de != 0);
        while (ticks < kt && cyc < 20000) begin
            if (tick_o) begin
                int exp_p;
                ticks++;
                exp_p = ticks * (ip + 1) + (frac ? ((ticks - 1) * nu) / de : 0);
                check(req, pulses, exp_p, $sformatf("pulses before tick %0d", ticks));
                if (ip != 0)
                    check("R7", int'(prev_t), 0, "tick wider than one cycle");
            end
            prev_t = tick_o;
            begin
                logic [2:0] v;
                bit         hit;
                hit = (cyc % gap) == 0;
                v   = 3'b111;
                v[sel-1] = hit;
                src_en_i = v;
                if (hit) pulses++;
            end
            cyc++;
            @(negedge clk);
        end
        src_en_i = '0;
        check(req, ticks, kt, "ticks seen");
    endtask

    task automatic t_reset();
        check("R1", int'(tick_o), 0, "tick after reset");
        check("R1", int'(cfg_err_o), 0, "err after reset");
        measure("R1", 1, 0, 0, 0, 4, 1);
    endtask

    task automatic t_integer();
        do_apply(1, 3, 0, 5);
        check("R6", int'(cfg_err_o), 0, "err after good apply");
        measure("R3", 1, 3, 0, 5, 4, 1);
        do_apply(2, 1, 7, 0);
        measure("R3", 2, 1, 7, 0, 5, 3);
        do_apply(3, 255, 0, 0);
        measure("R3", 3, 255, 0, 0, 2, 1);
    endtask

    task automatic t_fraction();
        do_apply(2, 2, 1, 3);
        measure("R4", 2, 2, 1, 3, 8, 1);
        do_apply(3, 1, 1, 2);
        measure("R4", 3, 1, 1, 2, 7, 2);
        do_apply(1, 0, 5, 2);
        measure("R4", 1, 0, 5, 2, 6, 1);
    endtask

    task automatic t_boundary();
        do_apply(1, 0, 64, 64);
        check("R8", int'(cfg_err_o), 0, "64/64 accepted");
        measure("R8", 1, 0, 64, 64, 5, 1);
    endtask

    task automatic t_reject();
        do_apply(2, 3, 0, 0);
        do_apply(1, 0, 65, 4);
        check("R5", int'(cfg_err_o), 1, "num 65 refused");
        measure("R5", 2, 3, 0, 0, 3, 1);
        do_apply(1, 0, 2, 70);
        check("R5", int'(cfg_err_o), 1, "den 70 refused");
        do_apply(0, 0, 1, 1);
        check("R5", int'(cfg_err_o), 1, "source 0 refused");
        repeat (3) @(negedge clk);
        check("R6", int'(cfg_err_o), 1, "err held without apply");
        do_apply(3, 0, 0, 0);
        check("R6", int'(cfg_err_o), 0, "err cleared by good apply");
        measure("R2", 3, 0, 0, 0, 3, 2);
    endtask

    initial begin
        rst = 1'b1;
        src_en_i = '0; cfg_sel_i = '0; cfg_int_i = '0;
        cfg_num_i = '0; cfg_den_i = '0; cfg_apply_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_integer();
        t_fraction();
        t_boundary();
        t_reject();
        done = 1;
    end

    initial begin
        int n = 0;
        while (!done && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule